// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder with Bubble Suppression

This block sits behind the comparator bank of a parallel (flash) converter. It takes the 2^N−1 comparator decisions as a thermometer vector, in which ideally every level below the input is 1 and every level above is 0. It turns that vector into an N-bit binary code. Metastable comparators can leave a lone 1 or a lone 0 inside the opposite region. The block finds the top edge of the thermometer with three-input gates, and each gate needs two ones at and below its level and a zero above. A single bubble therefore does not move the code far. When more than one edge qualifies, the highest one wins.

The edge vector is reduced to a one-hot vector and registered. It is then encoded to binary in a second register, so code and flag appear two clocks after the vector is presented. A separate over-range comparator bit travels alongside the code through the same two registers.

Top module: `therm_bin_encoder`

## Requirements
- R1: Both `code_out` and `over_out` reflect the inputs sampled two rising clock edges earlier. A value driven before edge k appears after edge k+1.
- R2: Bit j of `therm_in` is the comparator for level j+1, so the LSB is the lowest threshold. A clean thermometer with its k lowest bits set yields code k.
- R3: An all-zero thermometer yields code 0.
- R4: An all-one thermometer yields the maximum code 2^N−1.
- R5: A single 0 inside a run of ones that starts at the bottom has no effect. The code is the level of the topmost 1 of that run.
- R6: A single 1 above the run of ones, whose level below it is 0, has no effect. The code is the length of the run.
- R7: Level L (1-based) is an edge when levels L−1 and L are 1 and level L+1 is 0. Level 0 counts as 1 and level 2^N as 0. When several levels are edges, the code is the highest such L.
- R8: `over_out` is the over-range bit delayed by two clocks, whatever the thermometer holds.
- R9: A synchronous active-high reset clears `code_out` and `over_out` at the next rising edge.
- R10: With only the lowest level set, the code is 1, because the missing level below counts as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| therm_in | input | 2^N−1 | Registered comparator decisions, LSB lowest level |
| over_in | input | 1 | Over-range comparator decision |
| code_out | output | N | Registered binary code |
| over_out | output | 1 | Registered over-range flag |

## Verification
Every result, code and flag alike, is due exactly two rising edges after its inputs are driven. The bench drives inputs on falling edges and pushes the expected code and flag into a queue. Two falling edges later it pops the entry and compares it with the outputs, so each comparison lands one half-period after the output register updates. Around reset, the queue is refilled with the zeros the cleared registers hold, and the cleared state is checked separately one edge after reset rises.

// File: rtl/therm_pkg.sv
package therm_pkg;
  function automatic int level_count(input int bits);
    return (1 << bits) - 1;
  endfunction
endpackage

// File: rtl/therm_edge_detect.sv
module therm_edge_detect #(
  parameter int LEVELS = 15
) (
  input  logic [LEVELS-1:0] therm,
  output logic [LEVELS-1:0] edge_mark
);
  // Level i+1 is an edge when two ones sit at/below it and a zero above.
  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    logic below;
    logic above;
    if (i == 0) begin : g_bot
      assign below = 1'b1;
    end else begin : g_mid_lo
      assign below = therm[i-1];
    end
    if (i == LEVELS - 1) begin : g_top
      assign above = 1'b0;
    end else begin : g_mid_hi
      assign above = therm[i+1];
    end
    assign edge_mark[i] = below & therm[i] & ~above;
  end
endmodule

// File: rtl/therm_top_select.sv
module therm_top_select #(
  parameter int LEVELS = 15
) (
  input  logic [LEVELS-1:0] edge_mark,
  output logic [LEVELS-1:0] hot
);
  logic seen;
  always_comb begin
    seen = 1'b0;
    hot  = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      hot[i] = edge_mark[i] & ~seen;
      seen   = seen | edge_mark[i];
    end
  end
endmodule

// File: rtl/therm_onehot_enc.sv
module therm_onehot_enc #(
  parameter int N      = 4,
  parameter int LEVELS = 15
) (
  input  logic [LEVELS-1:0] hot,
  output logic [N-1:0]      code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (hot[i]) code = code | N'(i + 1);
    end
  end
endmodule

// File: rtl/therm_bin_encoder.sv
module therm_bin_encoder #(
  parameter int N = 4,
  localparam int LEVELS = therm_pkg::level_count(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEVELS-1:0] therm_in,
  input  logic              over_in,
  output logic [N-1:0]      code_out,
  output logic              over_out
);
  logic [LEVELS-1:0] edge_mark;
  logic [LEVELS-1:0] hot_d;
  logic [LEVELS-1:0] hot_q;
  logic              over_q;
  logic [N-1:0]      code_d;

  therm_edge_detect #(.LEVELS(LEVELS)) u_detect (
    .therm(therm_in), .edge_mark(edge_mark)
  );

  therm_top_select #(.LEVELS(LEVELS)) u_select (
    .edge_mark(edge_mark), .hot(hot_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hot_q  <= '0;
      over_q <= 1'b0;
    end else begin
      hot_q  <= hot_d;
      over_q <= over_in;
    end
  end

  therm_onehot_enc #(.N(N), .LEVELS(LEVELS)) u_enc (
    .hot(hot_q), .code(code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_out <= '0;
      over_out <= 1'b0;
    end else begin
      code_out <= code_d;
      over_out <= over_q;
    end
  end
endmodule

// File: rtl/therm_bin_encoder_chk.sv
module therm_bin_encoder_chk #(
  parameter int N = 4,
  localparam int LEVELS = therm_pkg::level_count(N)
) (
  input logic              clk,
  input logic              rst,
  input logic [LEVELS-1:0] therm_in,
  input logic              over_in,
  input logic [N-1:0]      code_out,
  input logic              over_out,
  input logic [LEVELS-1:0] hot
);
  logic [1:0] armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 2'd0;
    else if (armed != 2'd2) armed <= armed + 2'd1;
  end

  function automatic logic is_clean(input logic [LEVELS-1:0] t);
    return ((t & (t + 1'b1)) == '0);
  endfunction

  p_over_delay_r8: assert property (@(posedge clk) disable iff (rst)
    (armed == 2'd2) |-> (over_out == $past(over_in, 2)));

  p_latency_clean_r2: assert property (@(posedge clk) disable iff (rst)
    (armed == 2'd2 && is_clean($past(therm_in, 2)))
      |-> (int'(code_out) == $countones($past(therm_in, 2))));

  p_zero_code_r3: assert property (@(posedge clk) disable iff (rst)
    (armed == 2'd2 && $past(therm_in, 2) == '0) |-> (code_out == '0));

  p_full_code_r4: assert property (@(posedge clk) disable iff (rst)
    (armed == 2'd2 && $past(therm_in, 2) == '1) |-> (code_out == '1));

  p_single_edge_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hot));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (code_out == '0 && !over_out));
endmodule

bind therm_bin_encoder therm_bin_encoder_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .therm_in(therm_in), .over_in(over_in),
  .code_out(code_out), .over_out(over_out), .hot(hot_q)
);

// File: tb/therm_bin_encoder_test.sv
module therm_bin_encoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int LEVELS = (1 << N) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [LEVELS-1:0] therm_in = '0;
  logic              over_in = 1'b0;
  logic [N-1:0]      code_out;
  logic              over_out;

  int checks = 0;
  int errors = 0;
  int exp_code_q[$];
  bit exp_over_q[$];
  string tag_q[$];

  therm_bin_encoder #(.N(N)) uut (
    .clk(clk), .rst(rst), .therm_in(therm_in), .over_in(over_in),
    .code_out(code_out), .over_out(over_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: highest level L with levels L-1 and L set and L+1 clear.
  function automatic int ref_code(input logic [LEVELS-1:0] t);
    for (int lvl = LEVELS; lvl >= 1; lvl--) begin
      bit lo = (lvl == 1) ? 1'b1 : t[lvl-2];
      bit hi = (lvl == LEVELS) ? 1'b0 : t[lvl];
      if (lo && t[lvl-1] && !hi) return lvl;
    end
    return 0;
  endfunction

  function automatic logic [LEVELS-1:0] run(input int k);
    logic [LEVELS-1:0] v = '0;
    for (int i = 0; i < k; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic compare_due();
    if (exp_code_q.size() >= 2) begin
      int ec = exp_code_q.pop_front();
      bit eo = exp_over_q.pop_front();
      string tg = tag_q.pop_front();
      checks++;
      if (int'(code_out) != ec || over_out != eo) begin
        errors++;
        $display("FAIL %s: code=%0d over=%0b expected code=%0d over=%0b",
                 tg, code_out, over_out, ec, eo);
      end
    end
  endtask

  task automatic step(input logic [LEVELS-1:0] t, input logic o, input string tg);
    @(negedge clk);
    compare_due();
    therm_in = t;
    over_in  = o;
    exp_code_q.push_back(ref_code(t));
    exp_over_q.push_back(o);
    tag_q.push_back(tg);
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare_due();
    rst = 1'b1; therm_in = '0; over_in = 1'b0;
    exp_code_q.delete(); exp_over_q.delete(); tag_q.delete();
    @(negedge clk);
    checks++;
    if (code_out != '0 || over_out != 1'b0) begin
      errors++;
      $display("FAIL R9: code=%0d over=%0b expected code=0 over=0", code_out, over_out);
    end
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 2; i++) begin
      exp_code_q.push_back(0); exp_over_q.push_back(1'b0); tag_q.push_back("R9");
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: impulse of a full code between zeros shows the two-edge latency
    step('0, 1'b0, "R1");
    step('1, 1'b1, "R1");
    step('0, 1'b0, "R1");
    // R3
    step('0, 1'b0, "R3");
    // R2: every clean thermometer
    for (int k = 0; k <= LEVELS; k++) step(run(k), 1'b0, "R2");
    // R4
    step('1, 1'b0, "R4");
    // R5: single 0 inside the run
    step(run(10) & ~(LEVELS'(1) << 4), 1'b0, "R5");
    step(run(LEVELS) & ~(LEVELS'(1) << 7), 1'b0, "R5");
    // R6: lone 1 above the run
    step(run(3) | (LEVELS'(1) << 8), 1'b0, "R6");
    step(run(0) | (LEVELS'(1) << 12), 1'b0, "R6");
    // R7: two separate runs, the higher edge wins
    step(run(3) | (run(4) << 5), 1'b0, "R7");
    step(run(2) | (run(3) << 6) | (run(2) << 12), 1'b0, "R7");
    // R10
    step(LEVELS'(1), 1'b0, "R10");
    // R8: flag independent of the code
    step('0, 1'b1, "R8");
    step(run(7), 1'b1, "R8");
    step('1, 1'b0, "R8");
    // R7: pseudo-random vectors against the reference
    for (int i = 0; i < 200; i++) step(LEVELS'($urandom), 1'($urandom), "R7");
    // R9: reset in mid-stream
    step('1, 1'b1, "R9");
    do_reset();
    step(run(5), 1'b1, "R2");
    step(run(9), 1'b0, "R2");
    step('0, 1'b0, "R3");
    step('0, 1'b0, "R3");
    step('0, 1'b0, "R3");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule